// File: doc/BRIEF.md
# Dual-Style Parallel Host Port

This block is the host-side front end of a character display controller. A host processor reaches it over an asynchronous parallel bus. A static strap selects one of two strobe conventions. In the first, an enable strobe and a read/write level are used together. In the second, separate active-low write and read strobes are used. A register-select pin steers each access to either the instruction/status path or the data path. The pins are synchronised into the core clock domain, and a small state machine then decides whether the bus is idle, in a write, or in a read.

The bus width can be changed at run time. After reset the port moves whole bytes on all eight data lines. When an instruction-path write matches the function-set pattern, its width bit selects 8-bit or 4-bit operation. In 4-bit mode only the upper four lines carry information. A write byte is assembled from two nibbles, high nibble first. A read byte is returned as two nibbles in the same order. The host does not need to poll between the two nibbles. Complete write bytes go to the command engine as a one-cycle pulse. Completed reads are acknowledged to the engine so that it can advance its address.

The state machine has three states. ST_IDLE moves to ST_WRITE when the write condition appears. It moves to ST_READ when only the read condition appears. ST_WRITE returns to ST_IDLE on the capture edge, which is the enable falling or the write strobe rising, and it hands the held lines to the nibble stage. ST_READ drives the data lines and returns to ST_IDLE when the read condition drops, which completes one nibble or one byte.

Top module: `hbi_host_port`

## Requirements
- R1: After reset the port is in 8-bit mode (`wide_mode`=1), `bus_oe` is 0, and `cmd_valid` and `rd_ack` are 0.
- R2: With `style_split`=0, `ctl_a` is the enable and `ctl_b` is the read/write level (0 means write). A write is captured when the enable falls. `cmd_valid` then pulses for exactly one cycle, visible after the third rising clock edge that follows the falling edge.
- R3: With `style_split`=1, `ctl_a` is an active-low write strobe and `ctl_b` is an active-low read strobe. A write is captured when `ctl_a` rises, with the same three-edge latency. The write strobe takes priority if both strobes are low.
- R4: In 8-bit mode every write delivers all eight lines on `cmd_byte`, together with the register-select level on `cmd_rs`.
- R5: A completed write with rs=0 whose bits 7..5 are 001 sets the width from bit 4 (1 selects 8-bit, 0 selects 4-bit). The same pattern written with rs=1, or any other byte, leaves `wide_mode` unchanged.
- R6: In 4-bit mode only lines 7..4 are taken and lines 3..0 are ignored. The first write supplies the high nibble and gives no `cmd_valid`. The second write supplies the low nibble and produces the assembled byte.
- R7: `bus_oe` is 1 only while a read condition is held (in enable style, enable high with the level at 1; in split style, the read strobe low). It is 0 during writes and after the read ends.
- R8: While driving in 8-bit mode, `bus_dout` returns `stat_byte` when rs=0 and `data_byte` when rs=1.
- R9: In 4-bit mode the first read drives the high nibble of the selected byte on lines 7..4. The second read drives the low nibble there. Lines 3..0 stay 0 in both reads.
- R10: The nibble phase restarts at "high nibble next" on reset and whenever the width changes, so the first transfer after a switch is a high nibble or a whole byte.
- R11: `rd_ack` pulses for one cycle when a read byte completes (on the one read in 8-bit mode, on the second read in 4-bit mode) and carries that read's register select on `ack_rs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| style_split | input | 1 | Strap: 0 = enable plus read/write level, 1 = separate strobes |
| ctl_a | input | 1 | Enable (style 0) or active-low write strobe (style 1) |
| ctl_b | input | 1 | Read/write level (style 0) or active-low read strobe (style 1) |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_din | input | 8 | Data lines as seen by the port |
| stat_byte | input | 8 | Status byte from the engine for instruction-path reads |
| data_byte | input | 8 | Data byte from the engine for data-path reads |
| bus_dout | output | 8 | Value driven onto the data lines |
| bus_oe | output | 1 | Data line drive enable; lines are released when 0 |
| cmd_valid | output | 1 | One-cycle pulse: a complete write byte is present |
| cmd_rs | output | 1 | Register select of the completed write byte |
| cmd_byte | output | 8 | Completed write byte |
| rd_ack | output | 1 | One-cycle pulse: a read byte completed |
| ack_rs | output | 1 | Register select of the completed read |
| wide_mode | output | 1 | Current width: 1 = 8-bit, 0 = 4-bit |

## Verification
Every pin change passes two synchroniser stages and one state register. A strobe edge therefore shows on `cmd_valid`, `bus_oe` or `rd_ack` after the third rising edge that follows it. `wide_mode` changes on the same edge as `cmd_valid`. Stimulus is applied on falling edges. The bench waits exactly three rising edges and samples on the next falling edge, so each result is read in the one cycle in which it is due. Single-cycle pulses are checked in that cycle only. A reference model in the bench tracks width and nibble order and predicts the byte for each of a seeded random run of writes and reads mixed across both strobe styles.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int BYTE_W         = 8;
    localparam int FSET_WIDTH_BIT = 4;
    localparam logic [2:0] FSET_TAG = 3'b001;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } hbi_state_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode (
    input  logic split_mode,
    input  logic ctl_a,
    input  logic ctl_b,
    output logic wr_on,
    output logic wr_off,
    output logic rd_on
);
    always_comb begin
        if (split_mode) begin
            // active-low strobes, write wins when both are low
            wr_on  = ~ctl_a;
            wr_off = ctl_a;
            rd_on  = ctl_a & ~ctl_b;
        end else begin
            // enable plus level; level 1 means read
            wr_on  = ctl_a & ~ctl_b;
            wr_off = ~ctl_a;
            rd_on  = ctl_a & ctl_b;
        end
    end
endmodule

// File: rtl/hbi_nibble.sv
module hbi_nibble
    import hbi_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ev,
    input  logic [DATA_W-1:0] wr_lines,
    input  logic              wr_rs,
    input  logic              rd_ev,
    input  logic              rd_rs,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_out,
    output logic              byte_rs,
    output logic              rd_ack,
    output logic              ack_rs,
    output logic              wide,
    output logic              lo_phase
);
    localparam int NIB_W = DATA_W / 2;

    logic [NIB_W-1:0]  hi_hold;
    logic [DATA_W-1:0] full;
    logic              done_wr;
    logic              done_rd;
    logic              is_fset;

    always_comb begin
        full    = wide ? wr_lines : {hi_hold, wr_lines[DATA_W-1 -: NIB_W]};
        done_wr = wr_ev & (wide | lo_phase);
        done_rd = rd_ev & (wide | lo_phase);
        is_fset = done_wr & ~wr_rs & (full[DATA_W-1 -: 3] == FSET_TAG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_out   <= '0;
            byte_rs    <= 1'b0;
            rd_ack     <= 1'b0;
            ack_rs     <= 1'b0;
            wide       <= 1'b1;
            lo_phase   <= 1'b0;
            hi_hold    <= '0;
        end else begin
            byte_valid <= done_wr;
            rd_ack     <= done_rd;
            if (done_wr) begin
                byte_out <= full;
                byte_rs  <= wr_rs;
            end
            if (done_rd) begin
                ack_rs <= rd_rs;
            end
            if (wr_ev && !wide && !lo_phase) begin
                hi_hold <= wr_lines[DATA_W-1 -: NIB_W];
            end
            if (is_fset && (full[FSET_WIDTH_BIT] != wide)) begin
                wide     <= full[FSET_WIDTH_BIT];
                lo_phase <= 1'b0;
            end else if ((wr_ev || rd_ev) && !wide) begin
                lo_phase <= ~lo_phase;
            end
        end
    end
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port
    import hbi_pkg::*;
#(
    parameter int DATA_W      = BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              style_split,
    input  logic              ctl_a,
    input  logic              ctl_b,
    input  logic              bus_rs,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [DATA_W-1:0] stat_byte,
    input  logic [DATA_W-1:0] data_byte,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              cmd_valid,
    output logic              cmd_rs,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              rd_ack,
    output logic              ack_rs,
    output logic              wide_mode
);
    localparam int NIB_W  = DATA_W / 2;
    localparam int BUND_W = DATA_W + 4;

    hbi_state_e        state_q, state_d;
    logic [BUND_W-1:0] s_bundle;
    logic              s_style, s_a, s_b, s_rs;
    logic [DATA_W-1:0] s_din;
    logic              wr_on, wr_off, rd_on;
    logic [DATA_W-1:0] hold_lines;
    logic              hold_rs, rd_rs_q;
    logic              wr_ev, rd_ev, lo_phase;
    logic [DATA_W-1:0] rd_src;

    hbi_sync #(.W(BUND_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({style_split, ctl_a, ctl_b, bus_rs, bus_din}),
        .q     (s_bundle)
    );

    assign {s_style, s_a, s_b, s_rs, s_din} = s_bundle;

    hbi_decode u_decode (
        .split_mode (s_style),
        .ctl_a      (s_a),
        .ctl_b      (s_b),
        .wr_on      (wr_on),
        .wr_off     (wr_off),
        .rd_on      (rd_on)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_on)      state_d = ST_WRITE;
                else if (rd_on) state_d = ST_READ;
            end
            ST_WRITE: if (wr_off) state_d = ST_IDLE;
            ST_READ:  if (!rd_on) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // registered outputs of the machine: held lines and read path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_lines <= '0;
            hold_rs    <= 1'b0;
            rd_rs_q    <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE && wr_on) || (state_q == ST_WRITE && !wr_off)) begin
                hold_lines <= s_din;
                hold_rs    <= s_rs;
            end
            if (state_q == ST_IDLE && !wr_on && rd_on) begin
                rd_rs_q <= s_rs;
            end
        end
    end

    assign wr_ev = (state_q == ST_WRITE) && wr_off;
    assign rd_ev = (state_q == ST_READ) && !rd_on;

    hbi_nibble #(.DATA_W(DATA_W)) u_nibble (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ev      (wr_ev),
        .wr_lines   (hold_lines),
        .wr_rs      (hold_rs),
        .rd_ev      (rd_ev),
        .rd_rs      (rd_rs_q),
        .byte_valid (cmd_valid),
        .byte_out   (cmd_byte),
        .byte_rs    (cmd_rs),
        .rd_ack     (rd_ack),
        .ack_rs     (ack_rs),
        .wide       (wide_mode),
        .lo_phase   (lo_phase)
    );

    // drive side
    always_comb begin
        rd_src = rd_rs_q ? data_byte : stat_byte;
        bus_oe = (state_q == ST_READ);
        if (!bus_oe)        bus_dout = '0;
        else if (wide_mode) bus_dout = rd_src;
        else if (lo_phase)  bus_dout = {rd_src[NIB_W-1:0], {NIB_W{1'b0}}};
        else                bus_dout = {rd_src[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
    end
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_rs,
    input logic [DATA_W-1:0] cmd_byte,
    input logic              rd_ack,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_dout,
    input logic              wide_mode
);
    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack);

    a_r11_ack_ends_drive: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> ($past(bus_oe) && !bus_oe));

    a_r9_low_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !wide_mode) |-> (bus_dout[3:0] == 4'h0));

    a_r5_width_from_fset: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode != $past(wide_mode)) |->
            (cmd_valid && !cmd_rs && cmd_byte[7:5] == 3'b001 && cmd_byte[4] == wide_mode));

    a_r7_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !bus_oe);
endmodule

bind hbi_host_port hbi_checker #(.DATA_W(DATA_W)) u_hbi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_rs    (cmd_rs),
    .cmd_byte  (cmd_byte),
    .rd_ack    (rd_ack),
    .bus_oe    (bus_oe),
    .bus_dout  (bus_dout),
    .wide_mode (wide_mode)
);

// File: tb/hbi_host_port_bench.sv
`timescale 1ns/1ps
module hbi_host_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       style_split = 1'b0;
    logic       ctl_a = 1'b0;
    logic       ctl_b = 1'b0;
    logic       bus_rs = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] stat_byte = 8'h00;
    logic [7:0] data_byte = 8'h00;
    logic [7:0] bus_dout, cmd_byte;
    logic       bus_oe, cmd_valid, cmd_rs, rd_ack, ack_rs, wide_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_wide = 1'b1;

    always #4 clk = ~clk;

    hbi_host_port u_hbi_host_port (
        .clk(clk), .rst_n(rst_n), .style_split(style_split), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .bus_rs(bus_rs), .bus_din(bus_din), .stat_byte(stat_byte), .data_byte(data_byte),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .cmd_valid(cmd_valid), .cmd_rs(cmd_rs),
        .cmd_byte(cmd_byte), .rd_ack(rd_ack), .ack_rs(ack_rs), .wide_mode(wide_mode)
    );

    function automatic bit next_width(input bit wide, input bit rs, input logic [7:0] b);
        return (!rs && b[7:5] == 3'b001) ? b[4] : wide;
    endfunction

    function automatic logic [7:0] read_src(input bit rs, input logic [7:0] st, input logic [7:0] dt);
        return rs ? dt : st;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go_style(input bit split);
        @(negedge clk);
        style_split = split;
        ctl_a = split;
        ctl_b = split;
        repeat (4) @(negedge clk);
    endtask

    task automatic pin_write(input bit rs, input logic [7:0] lines, output bit oe_mid,
                             output bit v, output logic [7:0] b, output bit brs);
        @(negedge clk);
        bus_rs = rs;
        bus_din = lines;
        if (style_split) ctl_a = 1'b0;
        else begin ctl_b = 1'b0; ctl_a = 1'b1; end
        repeat (4) @(negedge clk);
        oe_mid = bus_oe;
        if (style_split) ctl_a = 1'b1;
        else ctl_a = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        v = cmd_valid; b = cmd_byte; brs = cmd_rs;
    endtask

    task automatic pin_read(input bit rs, output bit oe, output logic [7:0] d,
                            output bit ack, output bit ars, output bit oe_after);
        @(negedge clk);
        bus_rs = rs;
        if (style_split) ctl_b = 1'b0;
        else begin ctl_b = 1'b1; ctl_a = 1'b1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        oe = bus_oe; d = bus_dout;
        if (style_split) ctl_b = 1'b1;
        else ctl_a = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ack = rd_ack; ars = ack_rs; oe_after = bus_oe;
    endtask

    task automatic host_write(input bit rs, input logic [7:0] val);
        bit oe_mid, v, brs;
        logic [7:0] b;
        string wtag;
        wtag = style_split ? "R3" : "R2";
        if (exp_wide) begin
            pin_write(rs, val, oe_mid, v, b, brs);
            check(oe_mid == 1'b0, "R7 no drive in write", oe_mid, 0);
            check(v == 1'b1, wtag, v, 1);
            check(b == val && brs == rs, "R4 byte and rs", {brs, b}, {rs, val});
        end else begin
            pin_write(rs, {val[7:4], 4'($urandom)}, oe_mid, v, b, brs);
            check(v == 1'b0, "R6 no byte after high nibble", v, 0);
            check(oe_mid == 1'b0, "R7 no drive in write", oe_mid, 0);
            pin_write(rs, {val[3:0], 4'($urandom)}, oe_mid, v, b, brs);
            check(v == 1'b1, wtag, v, 1);
            check(b == val && brs == rs, "R6 assembled byte", {brs, b}, {rs, val});
        end
        exp_wide = next_width(exp_wide, rs, val);
        check(wide_mode == exp_wide, "R5 width", wide_mode, exp_wide);
    endtask

    task automatic host_read(input bit rs);
        bit oe, ack, ars, oe_after;
        logic [7:0] d, src;
        stat_byte = 8'($urandom);
        data_byte = 8'($urandom);
        src = read_src(rs, stat_byte, data_byte);
        if (exp_wide) begin
            pin_read(rs, oe, d, ack, ars, oe_after);
            check(oe == 1'b1, "R7 drive during read", oe, 1);
            check(d == src, "R8 read byte", d, src);
            check(ack == 1'b1 && ars == rs, "R11 ack", {ack, ars}, {1'b1, rs});
            check(oe_after == 1'b0, "R7 release", oe_after, 0);
        end else begin
            pin_read(rs, oe, d, ack, ars, oe_after);
            check(oe == 1'b1, "R7 drive during read", oe, 1);
            check(d == {src[7:4], 4'h0}, "R9 high nibble", d, {src[7:4], 4'h0});
            check(ack == 1'b0, "R11 no ack mid byte", ack, 0);
            pin_read(rs, oe, d, ack, ars, oe_after);
            check(d == {src[3:0], 4'h0}, "R9 low nibble", d, {src[3:0], 4'h0});
            check(ack == 1'b1 && ars == rs, "R11 ack", {ack, ars}, {1'b1, rs});
            check(oe_after == 1'b0, "R7 release", oe_after, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(wide_mode == 1'b1 && bus_oe == 1'b0 && cmd_valid == 1'b0 && rd_ack == 1'b0,
              "R1 reset state", {wide_mode, bus_oe, cmd_valid, rd_ack}, 4'b1000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(wide_mode == 1'b1 && bus_oe == 1'b0, "R1 after release", {wide_mode, bus_oe}, 2'b10);

        // directed: both strobe styles, 8-bit
        host_write(1'b1, 8'hA5);          // R2
        host_read(1'b0);                  // R8 status path
        go_style(1'b1);
        host_write(1'b0, 8'h3C);          // R3, function set keeping 8-bit
        host_read(1'b1);                  // R8 data path
        host_write(1'b1, 8'h20);          // R5: pattern on data path, no change
        check(wide_mode == 1'b1, "R5 data path ignored", wide_mode, 1);
        host_write(1'b0, 8'h2F);          // R5 to 4-bit, R10 phase restarts
        check(wide_mode == 1'b0, "R5 now 4-bit", wide_mode, 0);
        host_write(1'b1, 8'hB7);          // R6 first transfer is a high nibble (R10)
        host_read(1'b0);                  // R9
        go_style(1'b0);
        host_write(1'b1, 8'h5E);
        host_read(1'b1);
        host_write(1'b0, 8'h30);          // back to 8-bit
        check(wide_mode == 1'b1, "R10 back to 8-bit", wide_mode, 1);
        host_write(1'b1, 8'hC3);          // R10 whole byte right after switch

        // constrained random mix
        for (int i = 0; i < 60; i++) begin
            int pick;
            bit rs;
            logic [7:0] val;
            pick = int'($urandom % 10);
            if (pick == 0) go_style(~style_split);
            rs = 1'($urandom);
            val = 8'($urandom);
            if (pick >= 7) begin
                rs = 1'b0;
                val = {3'b001, 1'($urandom), 4'($urandom)};
            end
            if (pick >= 1 && pick <= 3) host_read(rs);
            else host_write(rs, val);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule